// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes data between an A side and a B side. Each side has a data input, a data output and a per-group drive enable, so the block needs no tristate pins. Every group keeps two storage registers. The forward register holds a copy of the A input and the reverse register holds a copy of the B input. A drive direction and a live-or-stored choice decide what each enabled side presents.

The data path is split into groups of `GROUP_W` bits. Two groups of 8 bits is the default. Each group has its own active-low enable, its own direction bit, a capture strobe for each register and a source select for each direction. Tying the controls of all groups together makes one wide path.

The whole block runs on one system clock. The capture strobes are sampled on that clock and act on their rising transitions. All outputs are registered, so a change of source moves the output in a single clean step.

Top module: `xcvr_dual`

## Requirements
- R1: After synchronous reset, `a_oe`, `b_oe`, `a_out` and `b_out` are zero. Both storage registers of every group hold zero, so a stored-data read that follows reset returns zero.
- R2: When a group's `cap_ab` bit is low in one clock cycle and high in the next, that group's A input slice is copied into the forward register at that clock edge. This happens whatever the values of `oe_n` and `dir`.
- R3: When a group's `cap_ba` bit is low in one clock cycle and high in the next, that group's B input slice is copied into the reverse register at that clock edge. This happens whatever the values of `oe_n` and `dir`.
- R4: A group with `oe_n`=1 drives neither side one cycle later: its `a_oe` and `b_oe` bits are 0 and its output slices are zero. With no capture edge, both of its registers keep their contents.
- R5: A group with `oe_n`=0 and `dir`=0 sets `a_oe`=1 one cycle later. Its `a_out` slice then shows the B input sampled at that edge when `sel_ba`=0, or the reverse register when `sel_ba`=1. Its `b_out` slice is zero.
- R6: A group with `oe_n`=0 and `dir`=1 sets `b_oe`=1 one cycle later. Its `b_out` slice then shows the A input sampled at that edge when `sel_ab`=0, or the forward register when `sel_ab`=1. Its `a_out` slice is zero.
- R7: For each group, `a_oe` and `b_oe` are never 1 together.
- R8: Group g owns data bits [g*GROUP_W +: GROUP_W] and control bit g. Its controls have no effect on any other group.
- R9: A capture strobe held high captures only once. Later changes of the input while the strobe stays high leave the register unchanged.
- R10: When a select switches between live and stored data, the output goes from the old source's value straight to the new source's value on the next clock edge, with no value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | GROUPS | Active-low output enable, one bit per group |
| dir | input | GROUPS | Direction per group: 0 drives the A side, 1 drives the B side |
| cap_ab | input | GROUPS | Capture strobe for the forward (A) register |
| cap_ba | input | GROUPS | Capture strobe for the reverse (B) register |
| sel_ab | input | GROUPS | B-side source: 0 live A input, 1 forward register |
| sel_ba | input | GROUPS | A-side source: 0 live B input, 1 reverse register |
| a_in | input | GROUP_W*GROUPS | A side input data |
| b_in | input | GROUP_W*GROUPS | B side input data |
| a_out | output | GROUP_W*GROUPS | A side output data |
| a_oe | output | GROUPS | A side drive enable per group |
| b_out | output | GROUP_W*GROUPS | B side output data |
| b_oe | output | GROUPS | B side drive enable per group |

## Verification
A change to the enable, direction, select or live data shows on the outputs after exactly one clock edge. The bench drives inputs on the falling edge and samples at the next falling edge, which is one rising edge later. A capture strobe writes its register at the first rising edge that sees it high, and a stored-data read of that register shows the new value one edge after that. For this reason the bench always leaves at least two rising edges between a capture and the check that depends on it. In the select-switch test the bench samples on consecutive cycles, so any in-between value would be seen.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    XM_ISOLATE = 2'd0,
    XM_DRIVE_A = 2'd1,
    XM_DRIVE_B = 2'd2
  } xfer_mode_t;

  function automatic xfer_mode_t mode_of(input logic en_n, input logic to_b);
    if (en_n) return XM_ISOLATE;
    return to_b ? XM_DRIVE_B : XM_DRIVE_A;
  endfunction
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      q        <= '0;
    end else begin
      strobe_d <= strobe;
      if (strobe && !strobe_d) q <= din;
    end
  end
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] fwd_q, rev_q;
  xfer_mode_t   mode;

  xcvr_capture #(.W(W)) u_fwd (
    .clk(clk), .rst(rst), .strobe(cap_ab), .din(a_in), .q(fwd_q)
  );
  xcvr_capture #(.W(W)) u_rev (
    .clk(clk), .rst(rst), .strobe(cap_ba), .din(b_in), .q(rev_q)
  );

  assign mode = mode_of(oe_n, dir);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe  <= 1'b0;
      b_oe  <= 1'b0;
      a_out <= '0;
      b_out <= '0;
    end else begin
      a_oe  <= (mode == XM_DRIVE_A);
      b_oe  <= (mode == XM_DRIVE_B);
      a_out <= (mode == XM_DRIVE_A) ? (sel_ba ? rev_q : b_in) : '0;
      b_out <= (mode == XM_DRIVE_B) ? (sel_ab ? fwd_q : a_in) : '0;
    end
  end
endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual #(
  parameter int GROUP_W = 8,
  parameter int GROUPS  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GROUPS-1:0]         oe_n,
  input  logic [GROUPS-1:0]         dir,
  input  logic [GROUPS-1:0]         cap_ab,
  input  logic [GROUPS-1:0]         cap_ba,
  input  logic [GROUPS-1:0]         sel_ab,
  input  logic [GROUPS-1:0]         sel_ba,
  input  logic [GROUP_W*GROUPS-1:0] a_in,
  input  logic [GROUP_W*GROUPS-1:0] b_in,
  output logic [GROUP_W*GROUPS-1:0] a_out,
  output logic [GROUPS-1:0]         a_oe,
  output logic [GROUP_W*GROUPS-1:0] b_out,
  output logic [GROUPS-1:0]         b_oe
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = g * GROUP_W;
    xcvr_group #(.W(GROUP_W)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .oe_n   (oe_n[g]),
      .dir    (dir[g]),
      .cap_ab (cap_ab[g]),
      .cap_ba (cap_ba[g]),
      .sel_ab (sel_ab[g]),
      .sel_ba (sel_ba[g]),
      .a_in   (a_in[LO +: GROUP_W]),
      .b_in   (b_in[LO +: GROUP_W]),
      .a_out  (a_out[LO +: GROUP_W]),
      .a_oe   (a_oe[g]),
      .b_out  (b_out[LO +: GROUP_W]),
      .b_oe   (b_oe[g])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int GROUP_W = 8,
  parameter int GROUPS  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [GROUPS-1:0]         oe_n,
  input logic [GROUPS-1:0]         dir,
  input logic [GROUPS-1:0]         sel_ab,
  input logic [GROUPS-1:0]         sel_ba,
  input logic [GROUP_W*GROUPS-1:0] a_in,
  input logic [GROUP_W*GROUPS-1:0] b_in,
  input logic [GROUP_W*GROUPS-1:0] a_out,
  input logic [GROUPS-1:0]         a_oe,
  input logic [GROUP_W*GROUPS-1:0] b_out,
  input logic [GROUPS-1:0]         b_oe
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    localparam int LO = g * GROUP_W;

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
      !(a_oe[g] && b_oe[g])); // R7

    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
      oe_n[g] |=> (!a_oe[g] && !b_oe[g])); // R4

    AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
      !a_oe[g] |-> (a_out[LO +: GROUP_W] == '0)); // R4

    AST_B_QUIET: assert property (@(posedge clk) disable iff (rst)
      !b_oe[g] |-> (b_out[LO +: GROUP_W] == '0)); // R4

    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && !dir[g] && !sel_ba[g]) |=>
        (a_oe[g] && a_out[LO +: GROUP_W] == $past(b_in[LO +: GROUP_W]))); // R5

    AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[g] && dir[g] && !sel_ab[g]) |=>
        (b_oe[g] && b_out[LO +: GROUP_W] == $past(a_in[LO +: GROUP_W]))); // R6
  end
endmodule

bind xcvr_dual xcvr_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
  .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/tb_xcvr_dual.sv
module tb_xcvr_dual;
  localparam int GW = 8;
  localparam int NG = 2;
  localparam int DW = GW * NG;

  logic          clk = 1'b0;
  logic          rst;
  logic [NG-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [DW-1:0] a_in, b_in, a_out, b_out;
  logic [NG-1:0] a_oe, b_oe;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  xcvr_dual #(.GROUP_W(GW), .GROUPS(NG)) dut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
    .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in),
    .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  localparam logic [DW-1:0] A_ST = 16'hA51C;
  localparam logic [DW-1:0] B_ST = 16'h3C96;
  localparam logic [DW-1:0] A_LV = 16'h5AA5;
  localparam logic [DW-1:0] B_LV = 16'hC3E1;

  // {oe_n, dir, sel_ab, sel_ba, exp_a_oe, exp_b_oe}
  localparam logic [5:0] VEC [16] = '{
    6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
    6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
    6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 a_oe", 32'(a_oe), 0);
    check("R1 b_oe", 32'(b_oe), 0);
    check("R1 a_out", 32'(a_out), 0);
    check("R1 b_out", 32'(b_out), 0);
    oe_n = '0; dir = '1; sel_ab = '1; a_in = A_LV;
    @(negedge clk);
    check("R1 fwd reg zero", 32'(b_out), 0);
    dir = '0; sel_ba = '1; b_in = B_LV;
    @(negedge clk);
    check("R1 rev reg zero", 32'(a_out), 0);

    // R2 R3: capture while isolated
    oe_n = '1; a_in = A_ST; b_in = B_ST; cap_ab = '1; cap_ba = '1;
    @(negedge clk);
    cap_ab = '0; cap_ba = '0; a_in = A_LV; b_in = B_LV;
    @(negedge clk);
    check("R4 isolated a_out", 32'(a_out), 0);

    // function table walk, both groups same controls (R4 R5 R6 R7)
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] ea, eb;
      oe_n = {NG{VEC[i][5]}}; dir = {NG{VEC[i][4]}};
      sel_ab = {NG{VEC[i][3]}}; sel_ba = {NG{VEC[i][2]}};
      ea = VEC[i][1] ? (VEC[i][2] ? B_ST : B_LV) : '0;
      eb = VEC[i][0] ? (VEC[i][3] ? A_ST : A_LV) : '0;
      @(negedge clk);
      check($sformatf("R4/R5/R6 vec%0d a_oe", i), 32'(a_oe), {NG{VEC[i][1]}});
      check($sformatf("R4/R5/R6 vec%0d b_oe", i), 32'(b_oe), {NG{VEC[i][0]}});
      check($sformatf("R2/R3/R5 vec%0d a_out", i), 32'(a_out), 32'(ea));
      check($sformatf("R2/R3/R6 vec%0d b_out", i), 32'(b_out), 32'(eb));
      check($sformatf("R7 vec%0d one side", i), 32'(a_oe & b_oe), 0);
    end

    // R9: strobe held high captures once
    oe_n = '1; a_in = 16'h1111; cap_ab = '1;
    @(negedge clk);
    a_in = 16'h2222;
    @(negedge clk);
    cap_ab = '0; oe_n = '0; dir = '1; sel_ab = '1;
    @(negedge clk);
    check("R9 held strobe", 32'(b_out), 32'h1111);

    // R8: groups independent
    oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b10; sel_ba = 2'b00;
    b_in = 16'h77E4;
    @(negedge clk);
    check("R8 a_oe", 32'(a_oe), 32'b01);
    check("R8 b_oe", 32'(b_oe), 32'b10);
    check("R8 a_out", 32'(a_out), 32'h00E4);
    check("R8 b_out", 32'(b_out), 32'h1100);

    // R10: select switch takes one step; R4 hold over isolation
    oe_n = '1;
    repeat (3) begin b_in = b_in + 16'h0101; @(negedge clk); end
    oe_n = '0; dir = '0; sel_ba = '0; b_in = B_LV;
    @(negedge clk);
    check("R10 before switch", 32'(a_out), 32'(B_LV));
    sel_ba = '1;
    @(negedge clk);
    check("R10 after switch", 32'(a_out), 32'(B_ST));
    check("R4 rev reg held", 32'(a_out), 32'(B_ST));
    sel_ba = '0; b_in = 16'h0F0F;
    @(negedge clk);
    check("R10 back to live", 32'(a_out), 32'h0F0F);

    // R3: capture during drive A, then read stored
    b_in = 16'hBEEF; cap_ba = '1;
    @(negedge clk);
    cap_ba = '0; sel_ba = '1; b_in = 16'h0000;
    @(negedge clk);
    check("R3 capture while driving", 32'(a_out), 32'hBEEF);

    done = 1;
    summary();
    $finish;
  end
endmodule